// File: doc/BRIEF.md
# Bus Matrix Slave Port Arbiter

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Each master raises a request line while it wants the slave and flags the final beat of its burst on a separate input. The arbiter returns a one-hot grant vector and a single "connected" flag. A grant may land on a master that is not currently requesting: the slave is then parked on that master. A parked master starts its next access with no turnaround cycle. A master that has to wait for a fresh connection loses one cycle.

One configuration word, written through a simple write strobe, sets four things: round-robin or fixed-priority selection, the parking policy (none, last owner, or a programmed master), the index of the programmed master, and a slot limit. The slot limit caps how many consecutive cycles one burst may keep the slave while another master is waiting. A synthesis parameter gives a mask of the masters that are physically wired to this slave. Masters outside the mask are never granted. The bench drives bursts directly on the request and last-beat inputs, and there is no address or data path.

Top module: `xbar_slave_arb`

## Requirements
- R1: After reset the configuration word reads as 0x00000010. In that state the slot limit is 16, selection is round-robin and there is no parking. Field layout: bits 7:0 slot limit, bits 9:8 parking mode (0 none, 1 last owner, 2 programmed master, 3 treated as 0), bits 13:10 programmed master index, bit 16 selection (0 round-robin, 1 fixed priority). After reset, grant is all-zero and connected is low.
- R2: The grant vector is all-zero when connected is low and has exactly one bit set when connected is high.
- R3: In round-robin mode, the search for the next owner starts at the index one above the last granted master and wraps around.
- R4: In fixed-priority mode, the requesting master with the lowest index wins.
- R5: With parking mode 0, the slave disconnects when an access ends and no connected master is requesting. A master that requests while the slave is disconnected is granted on the next clock edge, which costs one extra cycle.
- R6: With parking mode 1, the slave stays granted to the last owner while idle. A new request from that owner therefore sees its grant already present. Before any access has completed a grant, the slave stays disconnected.
- R7: With parking mode 2, an idle slave is granted to the programmed master index, which then sees its grant already present.
- R8: With parking mode 2 and a programmed index that is outside the connection mask or at or above the master count, behaviour equals parking mode 0. Parking mode 3 also behaves as mode 0.
- R9: An owner that keeps requesting without a last beat holds the slave for at most the slot limit in cycles while another connected master requests. The grant moves on the clock edge after the limit is reached.
- R10: The slot limit has no effect when no other connected master is requesting. The owner keeps the grant.
- R11: A slot limit of 0 or 1 gives each contending master exactly one cycle in turn, with no deadlock.
- R12: A master outside the connection mask is never granted, even when it requests.
- R13: The grant changes only at an access end (last beat or dropped request), at slot expiry, or while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| mst_req | input | NUM_MST | Per-master request, held for the whole access |
| mst_last | input | NUM_MST | Per-master last-beat flag of the current burst |
| slv_gnt | output | NUM_MST | One-hot grant to the slave |
| slv_conn | output | 1 | Slave is attached to the granted master |

## Verification
The bench builds the arbiter with five masters and a connection mask of 0b01111. Four wired masters make the round-robin rotation and a full sweep of all fifteen fixed-priority request patterns possible, while the unwired fifth master keeps requesting and must never be granted. That same unwired index, together with index 9 (beyond the master count), reaches the parking fallback. The slot limit is reprogrammed to 16 (the reset value), 3, 2, 1 and 0, which covers pre-emption, the no-contender case and the degenerate limits.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

   localparam int          SLOT_W  = 8;
   localparam logic [31:0] CFG_RST = 32'h0000_0010;

   typedef enum logic [1:0] {
      PARK_NONE  = 2'd0,
      PARK_LAST  = 2'd1,
      PARK_FIXED = 2'd2,
      PARK_RSVD  = 2'd3
   } park_e;

   typedef struct packed {
      logic              arb_fixed;
      logic [3:0]        park_idx;
      park_e             park;
      logic [SLOT_W-1:0] slot;
   } cfg_t;

endpackage

// File: rtl/xbar_arb_cfg.sv
module xbar_arb_cfg
   import xbar_arb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [31:0] wdata,
   output cfg_t        cfg
);

   cfg_t cfg_rst_val;
   cfg_t cfg_in;
   logic unused_wbits;

   assign cfg_rst_val.slot      = CFG_RST[7:0];
   assign cfg_rst_val.park      = park_e'(CFG_RST[9:8]);
   assign cfg_rst_val.park_idx  = CFG_RST[13:10];
   assign cfg_rst_val.arb_fixed = CFG_RST[16];

   assign cfg_in.slot      = wdata[7:0];
   assign cfg_in.park      = park_e'(wdata[9:8]);
   assign cfg_in.park_idx  = wdata[13:10];
   assign cfg_in.arb_fixed = wdata[16];
   assign unused_wbits     = ^{wdata[31:17], wdata[15:14]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg <= cfg_rst_val;
      else if (we) cfg <= cfg_in;
   end

endmodule

// File: rtl/xbar_arb_pick.sv
module xbar_arb_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  cand,
   input  logic [IW-1:0] ptr,
   output logic [N-1:0]  rr_oh,
   output logic [N-1:0]  fp_oh
);

   // fixed priority: a prefix chain, lowest index first
   for (genvar i = 0; i < N; i++) begin : g_fp
      if (i == 0) begin : g_first
         assign fp_oh[0] = cand[0];
      end else begin : g_rest
         assign fp_oh[i] = cand[i] & ~|cand[i-1:0];
      end
   end

   // round robin: scan upward from ptr+1, wrapping
   if ((N & (N - 1)) == 0) begin : g_rr_pow2
      always_comb begin
         logic          taken;
         logic [IW-1:0] pos;
         rr_oh = '0;
         taken = 1'b0;
         for (int k = 1; k <= N; k++) begin
            pos = ptr + IW'(k);
            if (!taken && cand[pos]) begin
               rr_oh[pos] = 1'b1;
               taken      = 1'b1;
            end
         end
      end
   end else begin : g_rr_mod
      always_comb begin
         logic taken;
         int   pos;
         rr_oh = '0;
         taken = 1'b0;
         for (int k = 1; k <= N; k++) begin
            pos = (int'(ptr) + k) % N;
            if (!taken && cand[pos]) begin
               rr_oh[pos] = 1'b1;
               taken      = 1'b1;
            end
         end
      end
   end

   always_comb begin
      a_r4_fp_onehot: assert ($countones(fp_oh) == ((cand != '0) ? 1 : 0));
      a_r3_rr_subset: assert ((rr_oh & ~cand) == '0);
   end

endmodule

// File: rtl/xbar_arb_slot.sv
module xbar_arb_slot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         expire
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clr)                     cnt_q <= '0;
      else if (inc && (cnt_q != '1))    cnt_q <= cnt_q + W'(1);
   end

   // the current cycle is the limit-th held cycle (limit 0 acts as 1)
   assign expire = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit};

   a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt_q == '1) |=> (cnt_q == '1));

   a_r9_cnt_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb
   import xbar_arb_pkg::*;
#(
   parameter int               NUM_MST   = 16,
   parameter logic [NUM_MST-1:0] CONN_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [31:0]        cfg_wdata,
   input  logic [NUM_MST-1:0] mst_req,
   input  logic [NUM_MST-1:0] mst_last,
   output logic [NUM_MST-1:0] slv_gnt,
   output logic               slv_conn
);

   localparam int IW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

   if (NUM_MST < 2 || NUM_MST > 16) begin : g_bad_num
      $error("xbar_slave_arb: NUM_MST must lie in 2..16");
   end
   if (CONN_MASK == '0) begin : g_bad_mask
      $error("xbar_slave_arb: CONN_MASK must name at least one master");
   end

   cfg_t               cfg;
   logic [NUM_MST-1:0] gnt_q, gnt_d;
   logic               conn_q, conn_d;
   logic [IW-1:0]      last_q, last_d;
   logic               last_vld_q, last_vld_d;
   logic               cur_req, cur_end, others, slot_exp, expire_hit, hold;
   logic [NUM_MST-1:0] cand, rr_oh, fp_oh, win;
   logic               park_ok;

   xbar_arb_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   function automatic logic [IW-1:0] oh2idx(input logic [NUM_MST-1:0] oh);
      logic [IW-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_MST; i++)
         if (oh[i]) r = r | IW'(i);
      return r;
   endfunction

   assign cur_req    = |(gnt_q & mst_req);
   assign cur_end    = |(gnt_q & mst_last);
   assign others     = |(mst_req & CONN_MASK & ~gnt_q);
   assign expire_hit = conn_q && cur_req && slot_exp && others;
   assign hold       = conn_q && cur_req && !cur_end && !expire_hit;
   assign cand       = mst_req & CONN_MASK & ~(expire_hit ? gnt_q : '0);
   assign park_ok    = (int'(cfg.park_idx) < NUM_MST) &&
                       CONN_MASK[cfg.park_idx[IW-1:0]];

   xbar_arb_pick #(.N(NUM_MST), .IW(IW)) u_pick (
      .cand  (cand),
      .ptr   (last_q),
      .rr_oh (rr_oh),
      .fp_oh (fp_oh)
   );

   xbar_arb_slot #(.W(SLOT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!hold),
      .inc    (hold),
      .limit  (cfg.slot),
      .expire (slot_exp)
   );

   assign win = cfg.arb_fixed ? fp_oh : rr_oh;

   always_comb begin
      gnt_d      = gnt_q;
      conn_d     = conn_q;
      last_d     = last_q;
      last_vld_d = last_vld_q;
      if (hold) begin
         gnt_d = gnt_q;
      end else if (cand != '0) begin
         gnt_d      = win;
         conn_d     = 1'b1;
         last_d     = oh2idx(win);
         last_vld_d = 1'b1;
      end else begin
         gnt_d  = '0;
         conn_d = 1'b0;
         unique case (cfg.park)
            PARK_LAST: if (last_vld_q) begin
               gnt_d  = NUM_MST'(1) << last_q;
               conn_d = 1'b1;
            end
            PARK_FIXED: if (park_ok) begin
               gnt_d  = NUM_MST'(1) << cfg.park_idx[IW-1:0];
               conn_d = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q      <= '0;
         conn_q     <= 1'b0;
         last_q     <= IW'(NUM_MST - 1);
         last_vld_q <= 1'b0;
      end else begin
         gnt_q      <= gnt_d;
         conn_q     <= conn_d;
         last_q     <= last_d;
         last_vld_q <= last_vld_d;
      end
   end

   assign slv_gnt  = gnt_q;
   assign slv_conn = conn_q;

   a_r2_grant_shape: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(slv_gnt) == (slv_conn ? 1 : 0));

   a_r12_wired_only: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_gnt & ~CONN_MASK) == '0);

   a_r13_mid_burst_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_conn && |(slv_gnt & mst_req & ~mst_last) && !slot_exp) |=> $stable(slv_gnt));

   a_r9_preempt_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_conn && |(slv_gnt & mst_req) && slot_exp && |(mst_req & CONN_MASK & ~slv_gnt))
      |=> (slv_gnt != $past(slv_gnt)));

   a_r5_idle_disconnects: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg.park == PARK_NONE || cfg.park == PARK_RSVD) && (mst_req & CONN_MASK) == '0)
      |=> !slv_conn);

endmodule

// File: tb/xbar_slave_arb_tb.sv
module xbar_slave_arb_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 5;
   localparam logic [N-1:0] MASK = 5'b01111;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [31:0]  cfg_wdata = '0;
   logic [N-1:0] mst_req = '0;
   logic [N-1:0] mst_last = '0;
   logic [N-1:0] slv_gnt;
   logic         slv_conn;

   int n_tests = 0;
   int n_fail  = 0;
   logic finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xbar_slave_arb #(.NUM_MST(N), .CONN_MASK(MASK)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .mst_req   (mst_req),
      .mst_last  (mst_last),
      .slv_gnt   (slv_gnt),
      .slv_conn  (slv_conn)
   );

   task automatic chk(input string tag, input logic [N-1:0] gnt_exp, input logic conn_exp);
      n_tests++;
      if (slv_gnt !== gnt_exp || slv_conn !== conn_exp) begin
         n_fail++;
         $display("FAIL %s: actual gnt=%b conn=%b expected gnt=%b conn=%b",
                  tag, slv_gnt, slv_conn, gnt_exp, conn_exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [31:0] w);
      cfg_we    = 1'b1;
      cfg_wdata = w;
      step();
      cfg_we    = 1'b0;
      step();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] prev;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1 reset state", '0, 1'b0);

      // R1 + R9: default slot limit of 16 cycles, round robin from index 0
      mst_req = 5'b00011;
      for (int s = 1; s <= 16; s++) begin
         step();
         chk("R1 default slot hold", 5'b00001, 1'b1);
      end
      step();
      chk("R9 pre-empt at limit 16", 5'b00010, 1'b1);
      mst_req = '0;
      step();
      chk("R1 default no parking", '0, 1'b0);

      // R3 + R12: round robin rotation, unwired master 4 also requesting
      wr_cfg(32'h0000_00FF);
      mst_req  = 5'b11111;
      mst_last = 5'b11111;
      for (int k = 0; k < 8; k++) begin
         step();
         chk("R3 R12 round robin order", 5'(1) << ((2 + k) % 4), 1'b1);
      end
      mst_req  = '0;
      mst_last = '0;
      step();

      // R4: sweep all request patterns of the wired masters
      wr_cfg(32'h0001_00FF);
      for (int p = 1; p < 16; p++) begin
         mst_req  = {1'b1, 4'(p)};
         mst_last = 5'b11111;
         step();
         step();
         chk("R4 fixed priority lowest wins", {1'b0, 4'(p & -p)}, 1'b1);
      end
      mst_req  = '0;
      mst_last = '0;
      step();

      // R5: no parking, one-cycle penalty
      wr_cfg(32'h0000_00FF);
      step();
      chk("R5 idle disconnected", '0, 1'b0);
      mst_req = 5'b00001;
      #1 chk("R5 not attached at request", '0, 1'b0);
      step();
      chk("R5 granted one cycle later", 5'b00001, 1'b1);
      mst_req = '0;
      step();
      chk("R5 disconnect after end", '0, 1'b0);

      // R6: park on last owner
      wr_cfg(32'h0000_01FF);
      mst_req = 5'b00100;
      step();
      chk("R6 grant master 2", 5'b00100, 1'b1);
      mst_req = '0;
      step();
      step();
      chk("R6 parked on last", 5'b00100, 1'b1);
      mst_req = 5'b00100;
      #1 chk("R6 zero penalty", 5'b00100, 1'b1);
      step();
      chk("R6 still owner", 5'b00100, 1'b1);
      mst_req = 5'b00001;
      step();
      chk("R6 switch to master 0", 5'b00001, 1'b1);
      mst_req = '0;
      step();
      chk("R6 parked on new last", 5'b00001, 1'b1);

      // R7: park on programmed master 1
      wr_cfg(32'h0000_06FF);
      step();
      chk("R7 parked on master 1", 5'b00010, 1'b1);
      mst_req = 5'b00010;
      #1 chk("R7 zero penalty", 5'b00010, 1'b1);
      step();
      mst_req = 5'b01000;
      step();
      chk("R7 master 3 served", 5'b01000, 1'b1);
      mst_req = '0;
      step();
      chk("R7 back to programmed", 5'b00010, 1'b1);

      // R8: fallback to no parking
      wr_cfg(32'h0000_12FF);
      step();
      chk("R8 unwired index", '0, 1'b0);
      mst_req = 5'b00001;
      #1 chk("R8 penalty kept", '0, 1'b0);
      step();
      chk("R8 granted after penalty", 5'b00001, 1'b1);
      mst_req = '0;
      wr_cfg(32'h0000_26FF);
      step();
      chk("R8 index beyond count", '0, 1'b0);
      wr_cfg(32'h0000_03FF);
      step();
      chk("R8 reserved mode", '0, 1'b0);

      // R10: limit 2, lone requester keeps the slave
      wr_cfg(32'h0000_0002);
      mst_req = 5'b00001;
      for (int s = 0; s < 10; s++) begin
         step();
         chk("R10 no pre-empt alone", 5'b00001, 1'b1);
      end

      // R9: limit 3, contender arrives late
      wr_cfg(32'h0000_0003);
      mst_req = 5'b00011;
      step();
      for (int s = 0; s < 3; s++) begin
         chk("R9 master 1 slot", 5'b00010, 1'b1);
         step();
      end
      for (int s = 0; s < 3; s++) begin
         chk("R9 master 0 slot", 5'b00001, 1'b1);
         step();
      end
      chk("R9 back to master 1", 5'b00010, 1'b1);

      // R11: limit 1 then limit 0, strict alternation
      wr_cfg(32'h0000_0001);
      for (int lim = 1; lim >= 0; lim--) begin
         if (lim == 0) wr_cfg(32'h0000_0000);
         prev = slv_gnt;
         for (int s = 0; s < 6; s++) begin
            step();
            chk("R11 alternate each cycle",
                (prev == 5'b00001) ? 5'b00010 : 5'b00001, 1'b1);
            prev = slv_gnt;
         end
      end
      mst_req = '0;
      step();

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule